// File: doc/BRIEF.md
# System Reset Sequencer

This block gathers every reset request in a chip: power-on or brownout, the external reset pin, a fault detector, a watchdog timeout, and a reset bit written by the debug controller. The current operating mode decides which of these requests are honoured. When a request qualifies, the block runs a fixed sequence that lasts 66 oscillator cycles.

The sequence has two phases. In the first 50 cycles the option bits are loaded while the system clock stays gated. In the last 16 cycles the clock runs and the core and peripherals are still held in reset. At the start of the sequence the GPIO pins return to their default setup and the motor PWM outputs float. The PWM outputs move to their programmed off-state once the option bits are in.

After reset is released, the block reads the two vector bytes at program addresses 0002h and 0003h and presents the starting program counter. A reset requested only by the debug controller spares the debug unit. The highest-priority cause of the latest reset stays visible as a one-hot code.

Top module: `reset_sequencer`

## Requirements
- R1: In any mode other than stop (mode_i 2'b10), a reset sequence starts for any of these requests: por_i, pin_rst_i, fault_rst_i, dbg_rst_req_i, or wdt_timeout_i together with wdt_rst_en_i. A watchdog timeout with wdt_rst_en_i low starts nothing.
- R2: In stop mode, only por_i, pin_rst_i and fault_rst_i start a sequence. Watchdog and debug requests leave core_rst_o, pc_valid_o and cause_o unchanged.
- R3: A request sampled at a clock edge raises core_rst_o from that edge on, for exactly 66 consecutive cycles.
- R4: opt_load_o is high and sysclk_en_o low for the first 50 cycles of the sequence. For its last 16 cycles opt_load_o is low and sysclk_en_o high. Outside a sequence, sysclk_en_o is high.
- R5: gpio_dflt_o is high for exactly the first cycle of each sequence.
- R6: pwm_mode_o is 2'b01 (high-impedance) for the first 50 cycles. It is 2'b10 (off-state) from cycle 51 until the program counter is valid. After that it is 2'b00 (released).
- R7: dbg_rst_o follows core_rst_o unless the sequence was started by debug requests alone, in which case it stays low. Any other source, including one that restarts a running sequence, makes the reset include the debug unit.
- R8: cause_o is one-hot: bit 0 power-on, bit 1 pin, bit 2 fault, bit 3 watchdog, bit 4 debug. It holds the highest-priority qualifying source of the latest request, with priority in that bit order, so power-on clears every other bit.
- R9: A qualifying request during a sequence or a vector fetch restarts the count at cycle one, with pwm_mode_o back at high-impedance.
- R10: In the first cycle after core_rst_o falls, vec_rd_o is high with vec_addr_o = 16'h0002. In the next cycle vec_addr_o = 16'h0003. From the third cycle on, pc_valid_o is high and pc_o holds {byte at 0002h, byte at 0003h}.
- R11: While rst_n is low, the block shows the first cycle of a full sequence with cause_o = power-on. It continues that sequence once rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as power-on |
| por_i | input | 1 | Power-on or brownout request |
| pin_rst_i | input | 1 | Synchronised external reset pin request |
| fault_rst_i | input | 1 | Fault-detect reset request |
| wdt_timeout_i | input | 1 | Watchdog timeout |
| wdt_rst_en_i | input | 1 | Watchdog timeout is set up to reset |
| dbg_rst_req_i | input | 1 | Debug controller reset bit written to 1 |
| mode_i | input | 2 | 00 normal, 01 halt, 10 stop |
| vec_data_i | input | 8 | Program memory byte at vec_addr_o |
| core_rst_o | output | 1 | Core and peripheral reset |
| dbg_rst_o | output | 1 | Debug unit reset |
| opt_load_o | output | 1 | Option-bit initialisation phase |
| sysclk_en_o | output | 1 | System clock enable |
| gpio_dflt_o | output | 1 | GPIO default-configuration strobe |
| pwm_mode_o | output | 2 | 00 released, 01 high-impedance, 10 off-state |
| vec_rd_o | output | 1 | Vector byte read |
| vec_addr_o | output | 16 | Vector byte address |
| pc_o | output | 16 | Starting program counter |
| pc_valid_o | output | 1 | pc_o is valid |
| cause_o | output | 5 | One-hot cause of the latest reset |

## Verification
A request is captured at the edge that follows its drive. All sequence outputs change at that same edge and are read at the next falling edge as cycle 0. core_rst_o is high for cycles 0 to 65, and the clock and PWM phase changes at cycle 50. The vector reads fall at cycles 66 and 67, and pc_valid_o first shows at cycle 68. The bench walks a cycle index from each captured request and compares every output against expected values computed from that index at each falling edge. A restart resets the index to 0 at the capture edge of the new request.

// File: rtl/rsq_pkg.sv
// Shared types and constants for the reset sequencer.
// Assumes a single oscillator clock domain; clock gating is modelled as an enable.
package rsq_pkg;
    typedef enum logic [1:0] {
        ST_SEQ    = 2'b00,
        ST_VEC_HI = 2'b01,
        ST_VEC_LO = 2'b10,
        ST_RUN    = 2'b11
    } seq_state_t;

    typedef enum logic [1:0] {
        PWM_RELEASED = 2'b00,
        PWM_HIZ      = 2'b01,
        PWM_OFF      = 2'b10
    } pwm_mode_t;

    localparam logic [1:0] MODE_STOP = 2'b10;

    localparam int CAUSE_N   = 5;
    localparam int CZ_POR    = 0;
    localparam int CZ_PIN    = 1;
    localparam int CZ_FAULT  = 2;
    localparam int CZ_WDT    = 3;
    localparam int CZ_DBG    = 4;
endpackage

// File: rtl/rsq_src_filter.sv
// Qualifies reset requests against the operating mode and encodes the cause.
// Assumes inputs are already synchronous to clk. Purely combinational.
module rsq_src_filter
    import rsq_pkg::*;
(
    input  logic               por_i,
    input  logic               pin_i,
    input  logic               fault_i,
    input  logic               wdt_i,
    input  logic               wdt_en_i,
    input  logic               dbg_i,
    input  logic [1:0]         mode_i,
    output logic               req_o,
    output logic               full_o,
    output logic [CAUSE_N-1:0] cause_o
);
    logic               stop_mode;
    logic [CAUSE_N-1:0] valid;

    assign stop_mode = (mode_i == MODE_STOP);

    // Build the mode-qualified request vector in priority order.
    always_comb begin
        valid           = '0;
        valid[CZ_POR]   = por_i;
        valid[CZ_PIN]   = pin_i;
        valid[CZ_FAULT] = fault_i;
        valid[CZ_WDT]   = wdt_i & wdt_en_i & ~stop_mode;
        valid[CZ_DBG]   = dbg_i & ~stop_mode;
    end

    assign req_o  = |valid;
    assign full_o = |(valid & ~(CAUSE_N'(1) << CZ_DBG));

    // Keep only the lowest-index (highest-priority) qualified source.
    always_comb begin
        logic found;
        found   = 1'b0;
        cause_o = '0;
        for (int i = 0; i < CAUSE_N; i++) begin
            if (valid[i] && !found) begin
                cause_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsq_seq_ctr.sv
// Sequence state machine and the two-phase cycle counter.
// Phase one runs INIT_CYC oscillator cycles; phase two runs IDLE_CYC
// cycles of the (enabled) system clock. A request restarts from cycle zero.
module rsq_seq_ctr
    import rsq_pkg::*;
#(
    parameter int INIT_CYC = 50,
    parameter int IDLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       full_req_i,
    output seq_state_t state_o,
    output logic       in_init_o,
    output logic       seq_start_o,
    output logic       full_o
);
    localparam int TOTAL = INIT_CYC + IDLE_CYC;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] INIT_END = CNT_W'(INIT_CYC);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             full;

    // Advance the sequence, restarting on any qualified request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEQ;
            cnt   <= '0;
            full  <= 1'b1;
        end else if (req_i) begin
            state <= ST_SEQ;
            cnt   <= '0;
            full  <= full_req_i | (full & (state != ST_RUN));
        end else begin
            case (state)
                ST_SEQ: begin
                    if (cnt == LAST_CNT) state <= ST_VEC_HI;
                    else                 cnt   <= cnt + 1'b1;
                end
                ST_VEC_HI: state <= ST_VEC_LO;
                ST_VEC_LO: state <= ST_RUN;
                default:   state <= ST_RUN;
            endcase
        end
    end

    assign state_o     = state;
    assign in_init_o   = (state == ST_SEQ) && (cnt < INIT_END);
    assign seq_start_o = (state == ST_SEQ) && (cnt == '0);
    assign full_o      = full;
endmodule

// File: rtl/rsq_vec_fetch.sv
// Reads the two reset-vector bytes after reset and assembles the start PC.
// Assumes program memory returns vec_data_i in the same cycle as vec_addr_o.
// The high byte comes from the lower address.
module rsq_vec_fetch
    import rsq_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0002
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  seq_state_t           state_i,
    input  logic [ADDR_W/2-1:0]  vec_data_i,
    output logic                 vec_rd_o,
    output logic [ADDR_W-1:0]    vec_addr_o,
    output logic [ADDR_W-1:0]    pc_o,
    output logic                 pc_valid_o
);
    localparam int BYTE_W = ADDR_W / 2;

    logic [ADDR_W-1:0] pc_q;

    // Capture each vector byte in its own fetch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (state_i == ST_VEC_HI) begin
            pc_q[ADDR_W-1:BYTE_W] <= vec_data_i;
        end else if (state_i == ST_VEC_LO) begin
            pc_q[BYTE_W-1:0] <= vec_data_i;
        end
    end

    assign vec_rd_o   = (state_i == ST_VEC_HI) || (state_i == ST_VEC_LO);
    assign vec_addr_o = VEC_BASE + ADDR_W'(state_i == ST_VEC_LO);
    assign pc_o       = pc_q;
    assign pc_valid_o = (state_i == ST_RUN);
endmodule

// File: rtl/reset_sequencer.sv
// Top of the system reset sequencer: mode filter, two-phase counter,
// vector fetch, cause latch and PWM/GPIO/clock control decode.
// Assumes all request inputs are synchronous single-cycle or level signals.
module reset_sequencer
    import rsq_pkg::*;
#(
    parameter int               INIT_CYC = 50,
    parameter int               IDLE_CYC = 16,
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0002
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 por_i,
    input  logic                 pin_rst_i,
    input  logic                 fault_rst_i,
    input  logic                 wdt_timeout_i,
    input  logic                 wdt_rst_en_i,
    input  logic                 dbg_rst_req_i,
    input  logic [1:0]           mode_i,
    input  logic [ADDR_W/2-1:0]  vec_data_i,
    output logic                 core_rst_o,
    output logic                 dbg_rst_o,
    output logic                 opt_load_o,
    output logic                 sysclk_en_o,
    output logic                 gpio_dflt_o,
    output logic [1:0]           pwm_mode_o,
    output logic                 vec_rd_o,
    output logic [ADDR_W-1:0]    vec_addr_o,
    output logic [ADDR_W-1:0]    pc_o,
    output logic                 pc_valid_o,
    output logic [CAUSE_N-1:0]   cause_o
);
    logic               req;
    logic               full_req;
    logic [CAUSE_N-1:0] cause_now;
    seq_state_t         state;
    logic               in_init;
    logic               seq_start;
    logic               full;
    logic [CAUSE_N-1:0] cause_q;
    pwm_mode_t          pwm_mode;

    rsq_src_filter u_filter (
        .por_i    (por_i),
        .pin_i    (pin_rst_i),
        .fault_i  (fault_rst_i),
        .wdt_i    (wdt_timeout_i),
        .wdt_en_i (wdt_rst_en_i),
        .dbg_i    (dbg_rst_req_i),
        .mode_i   (mode_i),
        .req_o    (req),
        .full_o   (full_req),
        .cause_o  (cause_now)
    );

    rsq_seq_ctr #(
        .INIT_CYC (INIT_CYC),
        .IDLE_CYC (IDLE_CYC)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .full_req_i  (full_req),
        .state_o     (state),
        .in_init_o   (in_init),
        .seq_start_o (seq_start),
        .full_o      (full)
    );

    rsq_vec_fetch #(
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .vec_data_i (vec_data_i),
        .vec_rd_o   (vec_rd_o),
        .vec_addr_o (vec_addr_o),
        .pc_o       (pc_o),
        .pc_valid_o (pc_valid_o)
    );

    // Latch the cause of the most recent qualified request.
    always_ff @(posedge clk) begin
        if (!rst_n)   cause_q <= CAUSE_N'(1) << CZ_POR;
        else if (req) cause_q <= cause_now;
    end

    // Select PWM drive: float before option bits, off-state until running.
    always_comb begin
        if (state == ST_SEQ)      pwm_mode = in_init ? PWM_HIZ : PWM_OFF;
        else if (state == ST_RUN) pwm_mode = PWM_RELEASED;
        else                      pwm_mode = PWM_OFF;
    end

    assign core_rst_o  = (state == ST_SEQ);
    assign dbg_rst_o   = core_rst_o & full;
    assign opt_load_o  = in_init;
    assign sysclk_en_o = ~in_init;
    assign gpio_dflt_o = seq_start;
    assign pwm_mode_o  = pwm_mode;
    assign cause_o     = cause_q;
endmodule

// File: rtl/reset_sequencer_chk.sv
// Property checker for reset_sequencer, attached by bind.
// Counts reset cycles itself so the sequence length is checked without deep $past.
module reset_sequencer_chk #(
    parameter int INIT_CYC = 50,
    parameter int IDLE_CYC = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        por_i,
    input logic        pin_rst_i,
    input logic        fault_rst_i,
    input logic        wdt_timeout_i,
    input logic        dbg_rst_req_i,
    input logic [1:0]  mode_i,
    input logic        core_rst_o,
    input logic        dbg_rst_o,
    input logic        opt_load_o,
    input logic        sysclk_en_o,
    input logic        gpio_dflt_o,
    input logic [1:0]  pwm_mode_o,
    input logic        vec_rd_o,
    input logic [15:0] vec_addr_o,
    input logic        pc_valid_o,
    input logic [4:0]  cause_o
);
    localparam int TOTAL = INIT_CYC + IDLE_CYC;
    localparam int LEN_W = $clog2(TOTAL + 2) + 1;

    logic [LEN_W-1:0] run_len;

    // Count reset cycles since the latest sequence start.
    always_ff @(posedge clk) begin
        if (!rst_n)           run_len <= '0;
        else if (gpio_dflt_o) run_len <= LEN_W'(1);
        else if (core_rst_o)  run_len <= run_len + 1'b1;
    end

    // R1
    pin_starts_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_rst_i || fault_rst_i) |=> (core_rst_o && gpio_dflt_o));

    // R2
    stop_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && !core_rst_o && (wdt_timeout_i || dbg_rst_req_i)
         && !por_i && !pin_rst_i && !fault_rst_i) |=> !core_rst_o);

    // R3
    seq_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> (run_len == LEN_W'(TOTAL)));

    // R4
    clk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opt_load_o |-> (!sysclk_en_o && core_rst_o));

    // R6
    pwm_start_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_dflt_o |-> (pwm_mode_o == 2'b01));

    // R6
    pwm_off_after_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sysclk_en_o) && core_rst_o) |-> (pwm_mode_o == 2'b10));

    // R7
    dbg_full_on_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> dbg_rst_o);

    // R8
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause_o) == 1);

    // R10
    vec_first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> (vec_rd_o && vec_addr_o == 16'h0002));

    // R10
    pc_out_of_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid_o |-> (!core_rst_o && !vec_rd_o));
endmodule

bind reset_sequencer reset_sequencer_chk u_chk (.*);

// File: tb/reset_sequencer_test.sv
// Self-checking bench: directed corner cases plus seeded random requests.
module reset_sequencer_test;
    localparam int INIT = 50;
    localparam int TOT  = 66;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_i = 0, pin_rst_i = 0, fault_rst_i = 0;
    logic        wdt_timeout_i = 0, wdt_rst_en_i = 0, dbg_rst_req_i = 0;
    logic [1:0]  mode_i = 2'b00;
    logic [7:0]  vec_data_i;
    logic        core_rst_o, dbg_rst_o, opt_load_o, sysclk_en_o, gpio_dflt_o;
    logic [1:0]  pwm_mode_o;
    logic        vec_rd_o, pc_valid_o;
    logic [15:0] vec_addr_o, pc_o;
    logic [4:0]  cause_o;

    logic [7:0]  vhi = 8'h5A, vlo = 8'hC3;
    int          checks = 0, fails = 0;
    logic [4:0]  last_cz;

    always #2 clk = ~clk;

    assign vec_data_i = (vec_addr_o == 16'h0002) ? vhi :
                        (vec_addr_o == 16'h0003) ? vlo : 8'h00;

    reset_sequencer uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] exp_cause(input logic [1:0] m, input logic [5:0] s);
        // s = {dbg, wdt_en, wdt, fault, pin, por}
        logic stop;
        stop = (m == 2'b10);
        if (s[0])                    return 5'b00001;
        if (s[1])                    return 5'b00010;
        if (s[2])                    return 5'b00100;
        if (s[3] && s[4] && !stop)   return 5'b01000;
        if (s[5] && !stop)           return 5'b10000;
        return 5'b00000;
    endfunction

    // Compare every output against the cycle index k of the sequence.
    task automatic sample_k(input int k, input bit full, input logic [4:0] cz);
        logic [1:0] epwm;
        epwm = (k < INIT) ? 2'b01 : (k < TOT + 2) ? 2'b10 : 2'b00;
        chk(core_rst_o == (k < TOT), "R3 core_rst", core_rst_o, k < TOT);
        chk(opt_load_o == (k < INIT), "R4 opt_load", opt_load_o, k < INIT);
        chk(sysclk_en_o == !(k < INIT), "R4 sysclk_en", sysclk_en_o, !(k < INIT));
        chk(gpio_dflt_o == (k == 0), "R5 gpio_dflt", gpio_dflt_o, k == 0);
        chk(pwm_mode_o == epwm, "R6 pwm_mode", pwm_mode_o, epwm);
        chk(dbg_rst_o == ((k < TOT) && full), "R7 dbg_rst", dbg_rst_o, (k < TOT) && full);
        chk(cause_o == cz, "R8 cause", cause_o, cz);
        chk(vec_rd_o == (k == TOT || k == TOT + 1), "R10 vec_rd", vec_rd_o,
            k == TOT || k == TOT + 1);
        if (k == TOT)     chk(vec_addr_o == 16'h0002, "R10 addr hi", vec_addr_o, 16'h0002);
        if (k == TOT + 1) chk(vec_addr_o == 16'h0003, "R10 addr lo", vec_addr_o, 16'h0003);
        chk(pc_valid_o == (k >= TOT + 2), "R10 pc_valid", pc_valid_o, k >= TOT + 2);
        if (k >= TOT + 2) chk(pc_o == {vhi, vlo}, "R10 pc", pc_o, {vhi, vlo});
    endtask

    task automatic run_seq(input int from, input int upto, input bit full, input logic [4:0] cz);
        for (int k = from; k < upto; k++) begin
            if (k != from) @(negedge clk);
            sample_k(k, full, cz);
        end
        last_cz = cz;
    endtask

    // Drive a request for one edge; returns at the following falling edge.
    task automatic fire(input logic [5:0] s);
        {dbg_rst_req_i, wdt_rst_en_i, wdt_timeout_i, fault_rst_i, pin_rst_i, por_i} = s;
        @(negedge clk);
        {dbg_rst_req_i, wdt_rst_en_i, wdt_timeout_i, fault_rst_i, pin_rst_i, por_i} = '0;
    endtask

    task automatic idle_chk(input string tag);
        for (int i = 0; i < 3; i++) begin
            chk(core_rst_o == 1'b0, tag, core_rst_o, 0);
            chk(pc_valid_o == 1'b1, tag, pc_valid_o, 1);
            chk(cause_o == last_cz, tag, cause_o, last_cz);
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [5:0] s;
        logic [4:0] cz;
        void'($urandom(32'd4242));
        // R11: block reset looks like power-on, first cycle of full sequence
        repeat (3) @(negedge clk);
        chk(cause_o == 5'b00001, "R11 cause in reset", cause_o, 1);
        chk(dbg_rst_o == 1'b1, "R11 dbg_rst in reset", dbg_rst_o, 1);
        sample_k(0, 1, 5'b00001);
        rst_n = 1'b1;
        @(negedge clk);
        run_seq(1, TOT + 4, 1, 5'b00001);

        // R1: pin in normal mode
        fire(6'b000010); run_seq(0, TOT + 4, 1, 5'b00010);
        // R1 R7: debug-only spares debug unit
        fire(6'b100000); run_seq(0, TOT + 4, 0, 5'b10000);
        // R1: watchdog with reset enable in halt mode
        mode_i = 2'b01;
        vhi = 8'h12; vlo = 8'h34;
        fire(6'b011000); run_seq(0, TOT + 4, 1, 5'b01000);
        // R1: watchdog without reset enable is ignored
        mode_i = 2'b00;
        fire(6'b001000); idle_chk("R1 wdt no enable");
        // R2: stop mode ignores debug and watchdog
        mode_i = 2'b10;
        fire(6'b100000); idle_chk("R2 stop dbg");
        fire(6'b011000); idle_chk("R2 stop wdt");
        fire(6'b000100); run_seq(0, TOT + 4, 1, 5'b00100);
        // R8: power-on beats pin and debug
        mode_i = 2'b00;
        fire(6'b100011); run_seq(0, TOT + 4, 1, 5'b00001);
        // R9 R7: debug restart during a full sequence keeps debug reset
        fire(6'b000010); run_seq(0, 31, 1, 5'b00010);
        fire(6'b100000);
        chk(pwm_mode_o == 2'b01, "R9 restart hiz", pwm_mode_o, 1);
        run_seq(0, TOT + 4, 1, 5'b10000);
        // R9: fault after option phase of a debug-only sequence
        fire(6'b100000); run_seq(0, 56, 0, 5'b10000);
        fire(6'b000100);
        chk(pwm_mode_o == 2'b01, "R9 restart hiz late", pwm_mode_o, 1);
        run_seq(0, TOT + 4, 1, 5'b00100);
        // R9: restart during vector fetch
        fire(6'b000010); run_seq(0, TOT + 1, 1, 5'b00010);
        fire(6'b000001); run_seq(0, TOT + 4, 1, 5'b00001);

        // Random requests against bench-computed expectations (R1 R2 R7 R8)
        for (int it = 0; it < 40; it++) begin
            mode_i = 2'($urandom_range(0, 2));
            for (int b = 0; b < 6; b++) s[b] = ($urandom_range(0, 4) == 0);
            vhi = 8'($urandom); vlo = 8'($urandom);
            cz = exp_cause(mode_i, s);
            fire(s);
            if (cz != 5'b00000) run_seq(0, TOT + 4, (cz != 5'b10000), cz);
            else                idle_chk("R2 random no request");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule